// File: doc/BRIEF.md
# Boot Area Empty Check Selector

This block picks the memory the processor starts from after reset: the main flash array or the system memory that holds the factory loader. It decides while the option bytes are being loaded. It first fetches the boot configuration from the option-byte store. It then reads one word at the base of main flash. If that word reads as erased, the block marks the flash as blank. A blank flash turns a pin-requested main-flash boot into a system-memory boot, so an unprogrammed part still starts in the loader.

Software can read the blank flag and can write it, and its written value replaces the sampled one. Software can also start a fresh option load through a self-clearing reload bit. A fresh load samples the flash word again. Once the option bytes say "always main flash", the blank flag has no effect on the choice.

Top module: `boot_area_sel`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises: `empty_flag`=0, `boot_valid`=0, `boot_sys`=0, `launch_pend`=0, `load_busy`=1 and `opt_req`=1, so an option load starts straight after power reset.
- R2: A load first holds `opt_req` until `opt_ack`, and then holds `fl_req` with `fl_addr`=`FLASH_BASE` (default 0) until `fl_ack`. `load_busy` is low in the cycle after the `fl_ack` cycle.
- R3: When a load finishes, `empty_flag` becomes 1 if `fl_rdata` was all ones (0xFFFF_FFFF with the defaults) in the `fl_ack` cycle, and 0 otherwise.
- R4: With `opt_swsel_n`=1, the pin decides. `boot_pin`=1 gives `boot_sys`=1 (system memory). `boot_pin`=0 gives `boot_sys`=`empty_flag`, where 0 means main flash.
- R5: With `opt_swsel_n`=0, `boot_sys` is the inverse of `opt_boot_main`. With `opt_boot_main`=1 the choice is main flash even when `empty_flag`=1.
- R6: Outside a load the block issues no flash read, and `fl_rdata` has no effect on `empty_flag`.
- R7: A `sw_empty_we` pulse while `load_busy`=0 loads `sw_empty_wdata` into `empty_flag`, and `boot_sys` follows on the same clock edge. The pulse is ignored while `load_busy`=1.
- R8: A `sw_launch_set` pulse while `load_busy`=0 raises `load_busy` and `launch_pend` on the next edge. `launch_pend` clears on the edge that ends that load. A pulse while `load_busy`=1 is ignored.
- R9: `boot_sys` and `boot_valid` do not change while a load is running. `boot_valid` rises when the first load ends and stays high until reset.
- R10: `boot_pin`, `opt_swsel_n` and `opt_boot_main` are sampled in the `opt_ack` cycle. Later changes have no effect until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power reset, active low, asynchronous |
| boot_pin | input | 1 | Boot pin level; 0 asks for main flash |
| opt_req | output | 1 | Option-byte read request |
| opt_ack | input | 1 | Option-byte data valid, accepts the request |
| opt_swsel_n | input | 1 | Option: 1 lets the pin decide, 0 lets `opt_boot_main` decide |
| opt_boot_main | input | 1 | Option: 1 forces main flash when `opt_swsel_n`=0 |
| fl_req | output | 1 | Flash read request |
| fl_addr | output | FLASH_AW | Flash read address |
| fl_ack | input | 1 | Flash read data valid |
| fl_rdata | input | FLASH_DW | Flash read data |
| sw_empty_we | input | 1 | Software write strobe for the blank flag |
| sw_empty_wdata | input | 1 | Value written to the blank flag |
| sw_launch_set | input | 1 | Software request for a new option load |
| empty_flag | output | 1 | Blank-flash flag |
| launch_pend | output | 1 | Reload bit; clears when the load ends |
| load_busy | output | 1 | Option load in progress |
| boot_valid | output | 1 | Boot choice settled after the first load |
| boot_sys | output | 1 | 1 selects system memory, 0 selects main flash |

## Verification
The assertions check on every cycle that the boot choice and its valid bit hold still during a load, and that the blank flag changes only at the end of a load or on an accepted software write. They also check that the flash read follows the option handshake, that the reload bit drops when its load ends, and that a forced main-flash configuration never yields system memory. Only the bench scenarios can show the actual boot choice for each mix of pin, options and flash word, and that no stray flash reads happen between loads. The same holds for ignoring software writes and reload requests during a load, and for keeping the sampled pin after it changes.

// File: rtl/boot_sel_pkg.sv
package boot_sel_pkg;

   typedef enum logic [1:0] {
      LD_OPT   = 2'd0,
      LD_FLASH = 2'd1,
      LD_IDLE  = 2'd2
   } ld_state_e;

   // 1 = boot from system memory, 0 = boot from main flash
   function automatic logic pick_system(input logic swsel_n, input logic boot_main,
                                        input logic pin, input logic empty);
      if (!swsel_n) return !boot_main;
      return pin | empty;
   endfunction

endpackage

// File: rtl/boot_load_seq.sv
module boot_load_seq
   import boot_sel_pkg::*;
#(
   parameter int unsigned             FLASH_AW   = 32,
   parameter logic [FLASH_AW-1:0]     FLASH_BASE = '0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                opt_ack,
   input  logic                fl_ack,
   input  logic                launch_set,
   output logic                opt_req,
   output logic                fl_req,
   output logic [FLASH_AW-1:0] fl_addr,
   output logic                busy,
   output logic                opt_take,
   output logic                done,
   output logic                launch_pend
);

   ld_state_e state_q;
   logic      start;

   assign opt_req  = (state_q == LD_OPT);
   assign fl_req   = (state_q == LD_FLASH);
   assign fl_addr  = FLASH_BASE;
   assign busy     = (state_q != LD_IDLE);
   assign opt_take = opt_req & opt_ack;
   assign done     = fl_req & fl_ack;
   assign start    = (state_q == LD_IDLE) & launch_set;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= LD_OPT;
         launch_pend <= 1'b0;
      end else begin
         unique case (state_q)
            LD_OPT:   if (opt_ack)    state_q <= LD_FLASH;
            LD_FLASH: if (fl_ack)     state_q <= LD_IDLE;
            LD_IDLE:  if (launch_set) state_q <= LD_OPT;
            default:                  state_q <= LD_IDLE;
         endcase
         if (done)       launch_pend <= 1'b0;
         else if (start) launch_pend <= 1'b1;
      end
   end

   assert_flash_after_opt_R2: assert property (@(posedge clk) disable iff (!rst_n)
      opt_take |=> fl_req);
   assert_launch_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !launch_pend);
   assert_launch_starts_R8: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (busy && launch_pend));

endmodule

// File: rtl/boot_empty_flag.sv
module boot_empty_flag #(
   parameter int unsigned FLASH_DW    = 32,
   parameter bit          ERASED_ONES = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                done,
   input  logic                busy,
   input  logic [FLASH_DW-1:0] rdata,
   input  logic                sw_we,
   input  logic                sw_wdata,
   output logic                empty_q,
   output logic                empty_d
);

   logic blank;

   generate
      if (ERASED_ONES) begin : g_ones
         assign blank = &rdata;
      end else begin : g_zeros
         assign blank = ~|rdata;
      end
   endgenerate

   always_comb begin
      empty_d = empty_q;
      if (done)                empty_d = blank;
      else if (sw_we && !busy) empty_d = sw_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) empty_q <= 1'b0;
      else        empty_q <= empty_d;
   end

   assert_flag_only_on_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!done && !(sw_we && !busy)) |=> $stable(empty_q));
   assert_write_ignored_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> $stable(empty_q));

endmodule

// File: rtl/boot_area_decide.sv
module boot_area_decide
   import boot_sel_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic opt_take,
   input  logic opt_swsel_n,
   input  logic opt_boot_main,
   input  logic boot_pin,
   input  logic busy,
   input  logic done,
   input  logic empty_d,
   output logic boot_sys,
   output logic boot_valid
);

   logic swsel_q, bmain_q, pin_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         swsel_q    <= 1'b1;
         bmain_q    <= 1'b0;
         pin_q      <= 1'b0;
         boot_sys   <= 1'b0;
         boot_valid <= 1'b0;
      end else begin
         if (opt_take) begin
            swsel_q <= opt_swsel_n;
            bmain_q <= opt_boot_main;
            pin_q   <= boot_pin;
         end
         if (done || !busy) boot_sys <= pick_system(swsel_q, bmain_q, pin_q, empty_d);
         if (done) boot_valid <= 1'b1;
      end
   end

   assert_hold_during_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> ($stable(boot_sys) && $stable(boot_valid)));
   assert_valid_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      boot_valid |=> boot_valid);
   assert_forced_main_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (boot_valid && !busy && !swsel_q && bmain_q) |=> !boot_sys);

endmodule

// File: rtl/boot_area_sel.sv
module boot_area_sel #(
   parameter int unsigned         FLASH_AW    = 32,
   parameter int unsigned         FLASH_DW    = 32,
   parameter logic [FLASH_AW-1:0] FLASH_BASE  = '0,
   parameter bit                  ERASED_ONES = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                boot_pin,
   output logic                opt_req,
   input  logic                opt_ack,
   input  logic                opt_swsel_n,
   input  logic                opt_boot_main,
   output logic                fl_req,
   output logic [FLASH_AW-1:0] fl_addr,
   input  logic                fl_ack,
   input  logic [FLASH_DW-1:0] fl_rdata,
   input  logic                sw_empty_we,
   input  logic                sw_empty_wdata,
   input  logic                sw_launch_set,
   output logic                empty_flag,
   output logic                launch_pend,
   output logic                load_busy,
   output logic                boot_valid,
   output logic                boot_sys
);

   localparam int unsigned WORD_BYTES = FLASH_DW / 8;

   generate
      if (FLASH_DW < 8 || (FLASH_DW % 8) != 0) begin : g_bad_dw
         $error("boot_area_sel: FLASH_DW must be a whole number of bytes");
      end
      if (FLASH_AW < 2) begin : g_bad_aw
         $error("boot_area_sel: FLASH_AW too small");
      end
      if ((FLASH_BASE % WORD_BYTES) != 0) begin : g_bad_base
         $error("boot_area_sel: FLASH_BASE must be word aligned");
      end
   endgenerate

   logic opt_take, done, empty_d;

   boot_load_seq #(.FLASH_AW(FLASH_AW), .FLASH_BASE(FLASH_BASE)) u_seq (
      .clk, .rst_n,
      .opt_ack, .fl_ack,
      .launch_set (sw_launch_set),
      .opt_req, .fl_req, .fl_addr,
      .busy       (load_busy),
      .opt_take, .done, .launch_pend
   );

   boot_empty_flag #(.FLASH_DW(FLASH_DW), .ERASED_ONES(ERASED_ONES)) u_flag (
      .clk, .rst_n, .done,
      .busy     (load_busy),
      .rdata    (fl_rdata),
      .sw_we    (sw_empty_we),
      .sw_wdata (sw_empty_wdata),
      .empty_q  (empty_flag),
      .empty_d
   );

   boot_area_decide u_dec (
      .clk, .rst_n, .opt_take, .opt_swsel_n, .opt_boot_main, .boot_pin,
      .busy (load_busy),
      .done, .empty_d, .boot_sys, .boot_valid
   );

   assert_no_read_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(load_busy == 1'b0 && fl_req));
   assert_busy_drops_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_req && fl_ack) |=> !load_busy);

endmodule

// File: tb/sim_boot_area_sel.sv
`timescale 1ns/100ps
module sim_boot_area_sel;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        boot_pin = 1'b0;
   logic        opt_ack = 1'b0, opt_swsel_n = 1'b1, opt_boot_main = 1'b0;
   logic        fl_ack = 1'b0;
   logic [31:0] fl_rdata = '0;
   logic        sw_empty_we = 1'b0, sw_empty_wdata = 1'b0, sw_launch_set = 1'b0;
   logic        opt_req, fl_req, empty_flag, launch_pend, load_busy, boot_valid, boot_sys;
   logic [31:0] fl_addr;

   int total = 0;
   int bad   = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   boot_area_sel u0 (
      .clk, .rst_n, .boot_pin, .opt_req, .opt_ack, .opt_swsel_n, .opt_boot_main,
      .fl_req, .fl_addr, .fl_ack, .fl_rdata, .sw_empty_we, .sw_empty_wdata,
      .sw_launch_set, .empty_flag, .launch_pend, .load_busy, .boot_valid, .boot_sys
   );

   // {swsel_n, boot_main, pin, word[31:0], exp_empty, exp_sys}
   localparam logic [36:0] VEC [8] = '{
      {3'b101, 32'hFFFF_FFFF, 2'b11},
      {3'b100, 32'h0000_0000, 2'b00},
      {3'b101, 32'h1234_5678, 2'b01},
      {3'b010, 32'hFFFF_FFFF, 2'b10},
      {3'b000, 32'h0000_0001, 2'b01},
      {3'b110, 32'hFFFF_FFFE, 2'b00},
      {3'b011, 32'hFFFF_FFFF, 2'b10},
      {3'b111, 32'hFFFF_FFFF, 2'b11}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic wait_hi(ref logic sig, input string tag);
      int n = 0;
      while (sig !== 1'b1 && n < 50) begin
         @(negedge clk);
         n++;
      end
      if (n >= 50) chk(tag, 32'd0, 32'd1);
   endtask

   // serves one option read and one flash read; returns at the negedge after fl_ack
   task automatic serve(input logic sn, input logic bm, input logic pin, input logic [31:0] w);
      boot_pin = pin; opt_swsel_n = sn; opt_boot_main = bm;
      wait_hi(opt_req, "R2 opt_req");
      opt_ack = 1'b1;
      @(negedge clk);
      opt_ack = 1'b0;
      wait_hi(fl_req, "R2 fl_req");
      chk("R2 fl_addr", fl_addr, 32'h0);
      fl_rdata = w; fl_ack = 1'b1;
      @(negedge clk);
      fl_ack = 1'b0;
      chk("R2 busy low after read", {31'd0, load_busy}, 32'd0);
   endtask

   task automatic launch();
      sw_launch_set = 1'b1;
      @(negedge clk);
      sw_launch_set = 1'b0;
      chk("R8 launch busy", {31'd0, load_busy}, 32'd1);
      chk("R8 launch pend", {31'd0, launch_pend}, 32'd1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog act=hung exp=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] hold_sys;
      int reads;
      repeat (3) @(negedge clk);
      // R1 during reset
      chk("R1 empty", {31'd0, empty_flag}, 32'd0);
      chk("R1 valid", {31'd0, boot_valid}, 32'd0);
      chk("R1 sys", {31'd0, boot_sys}, 32'd0);
      chk("R1 pend", {31'd0, launch_pend}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 busy", {31'd0, load_busy}, 32'd1);
      chk("R1 opt_req", {31'd0, opt_req}, 32'd1);
      chk("R1 fl_req", {31'd0, fl_req}, 32'd0);

      // first load: R3, R4, R9 valid rises
      serve(1'b1, 1'b0, 1'b0, 32'hFFFF_FFFF);
      chk("R3 blank word", {31'd0, empty_flag}, 32'd1);
      chk("R4 blank redirect", {31'd0, boot_sys}, 32'd1);
      chk("R9 valid", {31'd0, boot_valid}, 32'd1);

      // vector table: R3 R4 R5 R8
      for (int i = 0; i < 8; i++) begin
         launch();
         serve(VEC[i][36], VEC[i][35], VEC[i][34], VEC[i][33:2]);
         chk($sformatf("R3 vec%0d empty", i), {31'd0, empty_flag}, {31'd0, VEC[i][1]});
         chk($sformatf("R4 R5 vec%0d sys", i), {31'd0, boot_sys}, {31'd0, VEC[i][0]});
         chk($sformatf("R8 vec%0d pend clear", i), {31'd0, launch_pend}, 32'd0);
      end

      // R9: outputs held while a load stalls, pin toggles meanwhile
      hold_sys = {31'd0, boot_sys};
      launch();
      for (int k = 0; k < 6; k++) begin
         boot_pin = ~boot_pin;
         @(negedge clk);
         chk("R9 sys held", {31'd0, boot_sys}, hold_sys);
         chk("R9 valid held", {31'd0, boot_valid}, 32'd1);
      end
      // R7 ignored while busy (stalled in option phase)
      sw_empty_we = 1'b1; sw_empty_wdata = ~empty_flag;
      hold_sys = {31'd0, empty_flag};
      @(negedge clk);
      sw_empty_we = 1'b0;
      chk("R7 write ignored busy", {31'd0, empty_flag}, hold_sys);
      serve(1'b1, 1'b0, 1'b0, 32'h0000_0000);
      chk("R4 pin main not blank", {31'd0, boot_sys}, 32'd0);

      // R10: pin change after load has no effect
      boot_pin = 1'b1;
      repeat (3) @(negedge clk);
      chk("R10 pin after load", {31'd0, boot_sys}, 32'd0);

      // R6: no re-evaluation outside load
      fl_rdata = 32'hFFFF_FFFF;
      reads = 0;
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         if (fl_req) reads++;
      end
      chk("R6 no reads", reads, 32'd0);
      chk("R6 flag unchanged", {31'd0, empty_flag}, 32'd0);

      // R7 software write when idle
      sw_empty_we = 1'b1; sw_empty_wdata = 1'b1;
      @(negedge clk);
      sw_empty_we = 1'b0;
      chk("R7 write sets", {31'd0, empty_flag}, 32'd1);
      chk("R7 sys follows", {31'd0, boot_sys}, 32'd1);
      sw_empty_we = 1'b1; sw_empty_wdata = 1'b0;
      @(negedge clk);
      sw_empty_we = 1'b0;
      chk("R7 write clears", {31'd0, empty_flag}, 32'd0);
      chk("R7 sys back", {31'd0, boot_sys}, 32'd0);

      // R5: forced main ignores software-set flag
      launch();
      serve(1'b0, 1'b1, 1'b1, 32'h0);
      sw_empty_we = 1'b1; sw_empty_wdata = 1'b1;
      @(negedge clk);
      sw_empty_we = 1'b0;
      chk("R5 forced main flag", {31'd0, empty_flag}, 32'd1);
      chk("R5 forced main sys", {31'd0, boot_sys}, 32'd0);

      // R8: launch while busy is ignored
      launch();
      boot_pin = 1'b0; opt_swsel_n = 1'b1;
      wait_hi(opt_req, "R8 opt_req");
      opt_ack = 1'b1;
      @(negedge clk);
      opt_ack = 1'b0;
      sw_launch_set = 1'b1;
      @(negedge clk);
      sw_launch_set = 1'b0;
      fl_rdata = 32'h0; fl_ack = 1'b1;
      @(negedge clk);
      fl_ack = 1'b0;
      repeat (2) @(negedge clk);
      chk("R8 busy launch ignored", {31'd0, load_busy}, 32'd0);
      chk("R8 pend clear", {31'd0, launch_pend}, 32'd0);

      // R1: second power reset clears flag and valid
      sw_empty_we = 1'b1; sw_empty_wdata = 1'b1;
      @(negedge clk);
      sw_empty_we = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 reset flag", {31'd0, empty_flag}, 32'd0);
      chk("R1 reset valid", {31'd0, boot_valid}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reload starts", {31'd0, opt_req}, 32'd1);

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule